// File: doc/BRIEF.md
# SDRAM Row-Activation Rule Monitor

This block watches the command stream that a memory controller sends to a four-bank mobile SDRAM. It decides, in the same cycle, whether each command is legal. For every bank it tracks whether a row is open, which row that is, and how many clocks have passed since the bank was last activated. A shared counter measures the time since the most recent activation to any bank.

From this state it checks three spacing rules:

- the activate-to-activate interval within one bank,
- the activate-to-column delay,
- the activate-to-activate interval between different banks.

It also enforces the open-row discipline: a read or write needs an open row, and an activate needs a closed bank. Each rule is given in picoseconds together with the clock period. The block turns each rule into a cycle count at elaboration by rounding up.

A legal command raises `cmd_ok` and updates the bank state. An illegal one raises `viol_flag` with a reason code and leaves every register untouched. The controller uses these outputs to hold back commands or to log faults.

Top module: `dram_act_checker`

## Requirements
- R1: After reset every bank is closed (`bank_open` all zero, `cur_row` zero) and every interval counter is saturated, so the first ACTIVE to any bank is accepted at once.
- R2: Each limit in cycles is the picosecond value divided by `CLK_PS`, rounded up. With the defaults (7500 ps clock) this gives 9 cycles same-bank activate spacing, 3 cycles activate-to-column and 2 cycles cross-bank activate spacing.
- R3: A READ (op 2) or WRITE (op 3) to a bank with no open row is rejected with code 1.
- R4: A READ or WRITE issued fewer than the activate-to-column cycles after the accepted ACTIVE of its bank is rejected with code 2. At exactly that many cycles it is accepted.
- R5: An ACTIVE (op 1) to a bank that already holds an open row is rejected with code 5. This check takes priority over every other ACTIVE check.
- R6: An ACTIVE to a closed bank fewer than the same-bank spacing cycles after that bank's previous accepted ACTIVE is rejected with code 3.
- R7: An ACTIVE to a bank other than the one last activated, issued fewer than the cross-bank spacing cycles after the last accepted ACTIVE, is rejected with code 4. Code 3 wins over code 4.
- R8: An accepted ACTIVE opens the bank with the given row. A PRECHARGE (op 4) is always accepted and closes the bank. `cur_row` shows the open row of the addressed bank, or zero if that bank is closed.
- R9: A rejected command changes no bank state and restarts no counter.
- R10: An idle cycle (`cmd_vld` low), a NOP (op 0) or an unused opcode (5 to 7) raises neither output and gives code 0. The counters still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_vld | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE |
| cmd_bank | input | 2 | Target bank |
| cmd_row | input | 13 | Row address for ACTIVE |
| cmd_ok | output | 1 | Command is legal and is taken |
| viol_flag | output | 1 | Command is illegal |
| viol_code | output | 3 | 0 none, 1 no open row, 2 column too early, 3 same-bank activate too early, 4 cross-bank activate too early, 5 row already open |
| bank_open | output | 4 | Open flag per bank |
| cur_row | output | 13 | Open row of the addressed bank, zero if closed |

## Verification
Two rules can fail together in the same cycle. An ACTIVE to a bank precharged shortly after its own activation can break both the same-bank window and the cross-bank window at once, and an ACTIVE to a still-open bank also falls inside both windows. Directed ACTIVE–PRECHARGE–ACTIVE runs provoke these overlaps, and dense random traffic produces more of them. The reported code is judged against a bench model that applies the priority order open-row, then same-bank, then cross-bank.

// File: rtl/dact_pkg.sv
// Package: command and reason encodings shared by the activation monitor,
// plus the rounding helper that turns picosecond limits into cycles.
// Assumes all limits are positive and the clock period is non-zero.
package dact_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4
    } dact_op_e;

    typedef enum logic [2:0] {
        RC_NONE     = 3'd0,
        RC_NO_ROW   = 3'd1,
        RC_COL_EARLY = 3'd2,
        RC_SAME_ACT = 3'd3,
        RC_CROSS_ACT = 3'd4,
        RC_ROW_OPEN = 3'd5
    } dact_code_e;

    // Round a picosecond limit up to whole clocks, never below one.
    function automatic int ps_to_cyc(input int lim_ps, input int clk_ps);
        int c;
        c = (lim_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dact_bank_track.sv
// Module: state of one bank, holding the open flag, the open row and a
// saturating count of cycles since the bank's last accepted ACTIVE.
// Assumes act_i and pre_i are never high together; they are already
// qualified by command acceptance.
module dact_bank_track #(
    parameter int ROW_W   = 13,
    parameter int CNT_W   = 4,
    parameter int CNT_MAX = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);

    // Open flag and row: set by ACTIVE, cleared by PRECHARGE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o <= 1'b0;
            row_o  <= '0;
        end else if (act_i) begin
            open_o <= 1'b1;
            row_o  <= row_i;
        end else if (pre_i) begin
            open_o <= 1'b0;
            row_o  <= '0;
        end
    end

    // Age counter: restarts at one after ACTIVE, saturates at SAT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= SAT;
        end else if (act_i) begin
            cnt_o <= CNT_W'(1);
        end else if (cnt_o != SAT) begin
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dact_act_spacing.sv
// Module: global record of the last accepted ACTIVE: which bank it hit,
// and a saturating count of cycles since it was issued.
// Assumes act_i is already qualified by acceptance.
module dact_act_spacing #(
    parameter int BANK_W = 2,
    parameter int G_W    = 2,
    parameter int G_MAX  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic [G_W-1:0]    gcnt_o,
    output logic [BANK_W-1:0] last_bank_o
);

    localparam logic [G_W-1:0] SAT = G_W'(G_MAX);

    // Global age counter and last-bank register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcnt_o      <= SAT;
            last_bank_o <= '0;
        end else if (act_i) begin
            gcnt_o      <= G_W'(1);
            last_bank_o <= bank_i;
        end else if (gcnt_o != SAT) begin
            gcnt_o <= gcnt_o + G_W'(1);
        end
    end

endmodule

// File: rtl/dact_rule_eval.sv
// Module: combinational judgement of one command against the bank state.
// It applies the ACTIVE priority row-open, same-bank, cross-bank and the
// column priority no-row, too-early. It assumes counters saturate at or
// above their limits.
module dact_rule_eval
    import dact_pkg::*;
#(
    parameter int NB       = 4,
    parameter int BANK_W   = 2,
    parameter int CNT_W    = 4,
    parameter int G_W      = 2,
    parameter int TRC_CYC  = 9,
    parameter int TRCD_CYC = 3,
    parameter int TRRD_CYC = 2
) (
    input  logic [2:0]                cmd_op,
    input  logic                      cmd_vld,
    input  logic [BANK_W-1:0]         cmd_bank,
    input  logic [NB-1:0]             open_i,
    input  logic [NB-1:0][CNT_W-1:0]  cnt_i,
    input  logic [G_W-1:0]            gcnt_i,
    input  logic [BANK_W-1:0]         last_bank_i,
    output logic                      ok_o,
    output logic                      bad_o,
    output dact_code_e                code_o
);

    localparam logic [CNT_W-1:0] TRC_L  = CNT_W'(TRC_CYC);
    localparam logic [CNT_W-1:0] TRCD_L = CNT_W'(TRCD_CYC);
    localparam logic [G_W-1:0]   TRRD_L = G_W'(TRRD_CYC);

    logic             sel_open;
    logic [CNT_W-1:0] sel_cnt;

    // Pick the addressed bank's state.
    always_comb begin
        sel_open = open_i[cmd_bank];
        sel_cnt  = cnt_i[cmd_bank];
    end

    // Decide legality and reason code.
    always_comb begin
        ok_o   = 1'b0;
        code_o = RC_NONE;
        if (cmd_vld) begin
            unique case (cmd_op)
                OP_ACT: begin
                    if (sel_open)
                        code_o = RC_ROW_OPEN;
                    else if (sel_cnt < TRC_L)
                        code_o = RC_SAME_ACT;
                    else if (last_bank_i != cmd_bank && gcnt_i < TRRD_L)
                        code_o = RC_CROSS_ACT;
                    else
                        ok_o = 1'b1;
                end
                OP_RD, OP_WR: begin
                    if (!sel_open)
                        code_o = RC_NO_ROW;
                    else if (sel_cnt < TRCD_L)
                        code_o = RC_COL_EARLY;
                    else
                        ok_o = 1'b1;
                end
                OP_PRE:  ok_o = 1'b1;
                default: ok_o = 1'b0;
            endcase
        end
        bad_o = (code_o != RC_NONE);
    end

endmodule

// File: rtl/dram_act_checker.sv
// Module: top of the activation monitor. Derives cycle limits from the
// picosecond rules, keeps one tracker per bank and a global spacing
// record, and reports legality in the same cycle as the command.
// Assumes at most one command per cycle.
module dram_act_checker
    import dact_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int CLK_PS    = 7500,
    parameter int TRC_PS    = 67000,
    parameter int TRCD_PS   = 19000,
    parameter int TRRD_PS   = 15000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_vld,
    input  logic [2:0]                   cmd_op,
    input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
    input  logic [ROW_W-1:0]             cmd_row,
    output logic                         cmd_ok,
    output logic                         viol_flag,
    output logic [2:0]                   viol_code,
    output logic [NUM_BANKS-1:0]         bank_open,
    output logic [ROW_W-1:0]             cur_row
);

    localparam int BANK_W   = $clog2(NUM_BANKS);
    localparam int TRC_CYC  = ps_to_cyc(TRC_PS, CLK_PS);
    localparam int TRCD_CYC = ps_to_cyc(TRCD_PS, CLK_PS);
    localparam int TRRD_CYC = ps_to_cyc(TRRD_PS, CLK_PS);
    localparam int CNT_MAX  = imax(TRC_CYC, TRCD_CYC);
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int G_W      = $clog2(TRRD_CYC + 1);

    logic [NUM_BANKS-1:0]            trk_open;
    logic [NUM_BANKS-1:0][ROW_W-1:0] trk_row;
    logic [NUM_BANKS-1:0][CNT_W-1:0] trk_cnt;
    logic [G_W-1:0]                  gcnt;
    logic [BANK_W-1:0]               last_bank;
    logic                            ok_w;
    logic                            bad_w;
    dact_code_e                      code_w;
    logic                            acc_act;
    logic                            acc_pre;

    // Qualify state updates by acceptance.
    always_comb begin
        acc_act = ok_w && (cmd_op == OP_ACT);
        acc_pre = ok_w && (cmd_op == OP_PRE);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dact_bank_track #(
            .ROW_W  (ROW_W),
            .CNT_W  (CNT_W),
            .CNT_MAX(CNT_MAX)
        ) trk_i (
            .clk   (clk),
            .rst_n (rst_n),
            .act_i (acc_act && (cmd_bank == BANK_W'(b))),
            .pre_i (acc_pre && (cmd_bank == BANK_W'(b))),
            .row_i (cmd_row),
            .open_o(trk_open[b]),
            .row_o (trk_row[b]),
            .cnt_o (trk_cnt[b])
        );
    end

    dact_act_spacing #(
        .BANK_W(BANK_W),
        .G_W   (G_W),
        .G_MAX (TRRD_CYC)
    ) spc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_i      (acc_act),
        .bank_i     (cmd_bank),
        .gcnt_o     (gcnt),
        .last_bank_o(last_bank)
    );

    dact_rule_eval #(
        .NB      (NUM_BANKS),
        .BANK_W  (BANK_W),
        .CNT_W   (CNT_W),
        .G_W     (G_W),
        .TRC_CYC (TRC_CYC),
        .TRCD_CYC(TRCD_CYC),
        .TRRD_CYC(TRRD_CYC)
    ) eval_i (
        .cmd_op     (cmd_op),
        .cmd_vld    (cmd_vld),
        .cmd_bank   (cmd_bank),
        .open_i     (trk_open),
        .cnt_i      (trk_cnt),
        .gcnt_i     (gcnt),
        .last_bank_i(last_bank),
        .ok_o       (ok_w),
        .bad_o      (bad_w),
        .code_o     (code_w)
    );

    // Drive the outputs.
    always_comb begin
        cmd_ok    = ok_w;
        viol_flag = bad_w;
        viol_code = code_w;
        bank_open = trk_open;
        cur_row   = trk_row[cmd_bank];
    end

endmodule

// File: rtl/dact_checker.sv
// Module: assertions on the monitor's ports, bound to the top module.
// Assumes the default code and opcode encodings of dact_pkg.
module dact_checker #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cmd_vld,
    input logic [2:0]                   cmd_op,
    input logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
    input logic [ROW_W-1:0]             cmd_row,
    input logic                         cmd_ok,
    input logic                         viol_flag,
    input logic [2:0]                   viol_code,
    input logic [NUM_BANKS-1:0]         bank_open
);

    // R3
    no_row_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && (cmd_op == 3'd2 || cmd_op == 3'd3) && !bank_open[cmd_bank])
        |-> (viol_code == 3'd1));

    // R5
    row_open_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_op == 3'd1 && bank_open[cmd_bank]) |-> (viol_code == 3'd5));

    // R8
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cmd_op == 3'd1) |=> bank_open[$past(cmd_bank)]);

    // R8
    pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_op == 3'd4) |=> !bank_open[$past(cmd_bank)]);

    // R9
    reject_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |=> $stable(bank_open));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_vld || cmd_op == 3'd0 || cmd_op > 3'd4)
        |-> (!cmd_ok && !viol_flag && viol_code == 3'd0));

    // R10
    exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ok && viol_flag));

    logic unused_row;
    assign unused_row = ^cmd_row;

endmodule

bind dram_act_checker dact_checker #(
    .NUM_BANKS(NUM_BANKS),
    .ROW_W    (ROW_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_vld  (cmd_vld),
    .cmd_op   (cmd_op),
    .cmd_bank (cmd_bank),
    .cmd_row  (cmd_row),
    .cmd_ok   (cmd_ok),
    .viol_flag(viol_flag),
    .viol_code(viol_code),
    .bank_open(bank_open)
);

// File: tb/dram_act_checker_tb_top.sv
// Bench: directed corners plus seeded random traffic, compared each
// cycle against a model built from the requirements.
module dram_act_checker_tb_top;

    localparam int NB = 4;
    localparam int RW = 13;
    localparam int TRC = 9;    // R2: ceil(67000/7500)
    localparam int TRCD = 3;   // R2: ceil(19000/7500)
    localparam int TRRD = 2;   // R2: ceil(15000/7500)

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_vld = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [1:0]    cmd_bank = 2'd0;
    logic [RW-1:0] cmd_row = '0;
    logic          cmd_ok, viol_flag;
    logic [2:0]    viol_code;
    logic [NB-1:0] bank_open;
    logic [RW-1:0] cur_row;

    int n_chk = 0;
    int n_bad = 0;

    // Reference state.
    bit          m_open[NB];
    int          m_row[NB];
    int          m_cnt[NB];
    int          m_g;
    int          m_last;

    always #2 clk = ~clk;

    dram_act_checker dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_ok(cmd_ok),
        .viol_flag(viol_flag), .viol_code(viol_code),
        .bank_open(bank_open), .cur_row(cur_row)
    );

    function automatic int exp_code(input bit v, input int op, input int b);
        if (!v) return 0;
        if (op == 1) begin
            if (m_open[b]) return 5;
            if (m_cnt[b] < TRC) return 3;
            if (m_last != b && m_g < TRRD) return 4;
            return 0;
        end
        if (op == 2 || op == 3) begin
            if (!m_open[b]) return 1;
            if (m_cnt[b] < TRCD) return 2;
            return 0;
        end
        return 0;
    endfunction

    function automatic bit exp_ok(input bit v, input int op, input int b);
        if (!v) return 0;
        if (op >= 1 && op <= 4) return exp_code(v, op, b) == 0;
        return 0;
    endfunction

    function automatic string tag_of(input int code, input int op);
        case (code)
            1: return "R3";
            2: return "R4";
            3: return "R6";
            4: return "R7";
            5: return "R5";
            default: return (op == 0 || op > 4) ? "R10" : "R8";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NB; i++) begin
            m_open[i] = 0; m_row[i] = 0; m_cnt[i] = TRC;
        end
        m_g = TRRD; m_last = 0;
    endtask

    // Drive one command, compare at mid-cycle, advance the model.
    task automatic step(input bit v, input int op, input int b, input int row, input string note);
        bit eok; int ec; int erow; logic [NB-1:0] eopen;
        @(negedge clk);
        cmd_vld = v; cmd_op = 3'(op); cmd_bank = 2'(b); cmd_row = RW'(row);
        #1;
        ec = exp_code(v, op, b);
        eok = exp_ok(v, op, b);
        erow = m_open[b] ? m_row[b] : 0;
        for (int i = 0; i < NB; i++) eopen[i] = m_open[i];
        n_chk++;
        if (cmd_ok !== eok || viol_flag !== (ec != 0) || viol_code !== 3'(ec)
            || bank_open !== eopen || cur_row !== RW'(erow)) begin
            n_bad++;
            $display("FAIL %s %s: ok=%0b flag=%0b code=%0d open=%b row=%0d expected ok=%0b flag=%0b code=%0d open=%b row=%0d",
                     tag_of(ec, op), note, cmd_ok, viol_flag, viol_code, bank_open, cur_row,
                     eok, ec != 0, ec, eopen, erow);
        end
        @(posedge clk);
        for (int i = 0; i < NB; i++) if (m_cnt[i] < TRC) m_cnt[i]++;
        if (m_g < TRRD) m_g++;
        if (eok && op == 1) begin
            m_open[b] = 1; m_row[b] = row; m_cnt[b] = 1; m_g = 1; m_last = b;
        end else if (eok && op == 4) begin
            m_open[b] = 0; m_row[b] = 0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, "idle R10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state and immediate first ACTIVE
        step(0, 0, 0, 0, "R1 reset state");
        step(1, 1, 2, 77, "R1 first ACT");
        // R3 read to closed bank
        step(1, 2, 1, 0, "R3 read closed");
        // R4 column boundary: ACT at t, RD at t+1,t+2 fail, t+3 ok (R2)
        idle(TRRD);
        step(1, 1, 0, 5, "R4 ACT");
        step(1, 2, 0, 0, "R4 early 1");
        step(1, 3, 0, 0, "R4 early 2");
        step(1, 2, 0, 0, "R4 exact");
        // R5 re-ACT of open bank
        step(1, 1, 0, 9, "R5 open bank");
        // R6 same-bank window, overlapping R7 window
        idle(TRC);
        step(1, 1, 3, 11, "R6 ACT");
        step(1, 4, 3, 0, "R8 PRE");
        for (int k = 2; k < TRC; k++) step(1, 1, 3, 12, "R6 early");
        step(1, 1, 3, 12, "R6 exact");
        // R7 cross bank window
        step(1, 4, 0, 0, "R8 PRE b0");
        step(1, 4, 2, 0, "R8 PRE b2");
        idle(TRC);
        step(1, 1, 1, 21, "R7 ACT b1");
        step(1, 1, 2, 22, "R7 early b2");
        step(1, 1, 2, 22, "R7 exact b2");
        // R10 unused opcodes and NOP
        step(1, 0, 1, 0, "R10 nop");
        step(1, 6, 1, 0, "R10 unused op");
        step(0, 2, 0, 0, "R10 invalid read");
        // Random traffic (R9 via state compare after rejects)
        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            int op; int r;
            r = $urandom % 10;
            op = (r < 4) ? 1 : (r < 6) ? 4 : (r < 8) ? (2 + ($urandom % 2)) : (r == 8 ? 0 : 5 + ($urandom % 3));
            step(($urandom % 6) != 0, op, $urandom % NB, $urandom % (1 << RW), "random R9");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule